// File: doc/BRIEF.md
# Bit Test and Modify Unit

This block takes one operand word, picks a single bit of it by index, reports that bit's value as a carry flag and, in the same step, writes back an updated word. Four update policies are available: leave the word alone, force the chosen bit high, force it low, or invert it. The carry flag always carries the bit as it was before the update. This lets a datapath test a flag and claim it in one operation.

A request is offered with `in_valid` together with an operation code, the operand and a bit index. One clock later the result word, the carry flag and `out_valid` appear on registered outputs. The index is taken modulo the operand width, so only its low log2(WIDTH) bits matter. Operands that span more than one word are not handled. The width is a parameter, with 16 and 32 bits as the intended sizes.

Top module: `bit_probe_unit`

## Requirements
- R1: While reset is held and right after it, `out_valid`, `out_data` and `out_carry` are all 0.
- R2: `out_valid` is high in exactly those cycles that follow a cycle with `in_valid` high.
- R3: For every operation, `out_carry` equals the value of the selected bit of `in_data` before any update.
- R4: Operation code 2'b00 (test) returns `in_data` unchanged on `out_data`.
- R5: Operation code 2'b01 (set) returns `in_data` with the selected bit forced to 1.
- R6: Operation code 2'b10 (clear) returns `in_data` with the selected bit forced to 0.
- R7: Operation code 2'b11 (complement) returns `in_data` with the selected bit inverted.
- R8: No bit other than the selected one differs between `in_data` and the resulting `out_data`.
- R9: The selected bit position is `in_index` modulo WIDTH, that is, the low log2(WIDTH) bits of `in_index`. The higher index bits are ignored.
- R10: In a cycle after `in_valid` was low, `out_data` and `out_carry` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| in_op | input | 2 | Operation: 00 test, 01 set, 10 clear, 11 complement |
| in_data | input | WIDTH | Operand word |
| in_index | input | INDEX_W | Bit index, reduced modulo WIDTH |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_data | output | WIDTH | Updated operand |
| out_carry | output | 1 | Selected bit before the update |

## Verification
The bench uses directed words in which the chosen bit is 1 and others in which it is 0. This separates a carry taken before the update from one taken after it. Set on an already-set bit and clear on an already-clear bit show that those policies force a value rather than toggle it. Indices at bit 0, at the top bit, and above the width show whether the modulo reduction and the ends of the decoder are right. A long stream of random back-to-back requests with idle gaps then checks that the other bits pass through untouched and that the outputs hold while idle.

// File: rtl/bpu_pkg.sv
package bpu_pkg;

  typedef enum logic [1:0] {
    BPU_TEST  = 2'b00,
    BPU_SET   = 2'b01,
    BPU_CLEAR = 2'b10,
    BPU_FLIP  = 2'b11
  } bpu_op_e;

  // New value of the selected bit under a given policy.
  function automatic logic bpu_next_bit(bpu_op_e op, logic cur);
    logic nxt;
    case (op)
      BPU_TEST:  nxt = cur;
      BPU_SET:   nxt = 1'b1;
      BPU_CLEAR: nxt = 1'b0;
      default:   nxt = ~cur;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/bpu_index_decode.sv
module bpu_index_decode #(
  parameter int WIDTH   = 16,
  parameter int INDEX_W = 6,
  localparam int SEL_W  = $clog2(WIDTH)
) (
  input  logic [INDEX_W-1:0] index,
  output logic [SEL_W-1:0]   bit_pos,
  output logic [WIDTH-1:0]   sel_mask
);

  // Modulo-WIDTH reduction: only the low SEL_W bits select the position.
  assign bit_pos = index[SEL_W-1:0];

  for (genvar i = 0; i < WIDTH; i++) begin : g_mask
    assign sel_mask[i] = (bit_pos == SEL_W'(i));
  end

endmodule

// File: rtl/bpu_bit_update.sv
module bpu_bit_update
  import bpu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  bpu_op_e          op,
  input  logic [WIDTH-1:0] operand,
  input  logic [WIDTH-1:0] sel_mask,
  output logic [WIDTH-1:0] result,
  output logic             picked_bit
);

  assign picked_bit = |(operand & sel_mask);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign result[i] = sel_mask[i] ? bpu_next_bit(op, operand[i]) : operand[i];
  end

endmodule

// File: rtl/bit_probe_unit.sv
module bit_probe_unit
  import bpu_pkg::*;
#(
  parameter int WIDTH   = 16,
  parameter int INDEX_W = 6,
  localparam int SEL_W  = $clog2(WIDTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [1:0]         in_op,
  input  logic [WIDTH-1:0]   in_data,
  input  logic [INDEX_W-1:0] in_index,
  output logic               out_valid,
  output logic [WIDTH-1:0]   out_data,
  output logic               out_carry
);

  logic [SEL_W-1:0] bit_pos;
  logic [WIDTH-1:0] sel_mask;
  logic [WIDTH-1:0] upd_data;
  logic             upd_carry;
  bpu_op_e          op_q;

  assign op_q = bpu_op_e'(in_op);

  bpu_index_decode #(.WIDTH(WIDTH), .INDEX_W(INDEX_W)) u_decode (
    .index    (in_index),
    .bit_pos  (bit_pos),
    .sel_mask (sel_mask)
  );

  bpu_bit_update #(.WIDTH(WIDTH)) u_update (
    .op         (op_q),
    .operand    (in_data),
    .sel_mask   (sel_mask),
    .result     (upd_data),
    .picked_bit (upd_carry)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_carry <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_data  <= upd_data;
        out_carry <= upd_carry;
      end
    end
  end

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R2
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R3
  carry_before_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_carry == $past(in_data[in_index[SEL_W-1:0]]));

  // R4
  test_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == 2'b00) |=> out_data == $past(in_data));

  // R8
  single_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> $countones(out_data ^ $past(in_data)) <= 1);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_data) && $stable(out_carry)));

endmodule

// File: tb/bit_probe_unit_tb.sv
`timescale 1ns/1ps
module bit_probe_unit_tb;

  localparam int W  = 16;
  localparam int IW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [1:0]    in_op = 2'b00;
  logic [W-1:0]  in_data = '0;
  logic [IW-1:0] in_index = '0;
  logic          out_valid;
  logic [W-1:0]  out_data;
  logic          out_carry;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [W-1:0] data;
    logic         carry;
    string        tag;
  } exp_t;

  exp_t sb[$];
  logic [W-1:0] last_data  = '0;
  logic         last_carry = 1'b0;

  always #2 clk = ~clk;

  bit_probe_unit #(.WIDTH(W), .INDEX_W(IW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_data(in_data), .in_index(in_index), .out_valid(out_valid),
    .out_data(out_data), .out_carry(out_carry)
  );

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: computes the expected result with shifts, not masks.
  task automatic drive(input logic [1:0] op, input logic [W-1:0] d,
                       input logic [IW-1:0] idx, input string tag);
    int p;
    exp_t e;
    p = int'(idx) % W;
    e.carry = d[p];
    case (op)
      2'b00: e.data = d;
      2'b01: e.data = d | (W'(1) << p);
      2'b10: e.data = d & ~(W'(1) << p);
      default: e.data = d ^ (W'(1) << p);
    endcase
    e.tag = tag;
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_data = d; in_index = idx;
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_data  = $urandom();
      in_index = IW'($urandom());
      in_op    = 2'($urandom());
    end
  endtask

  // Monitor: compares results as they appear, and checks holding while idle.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (out_valid) begin
        if (sb.size() == 0) begin
          check("R2 unexpected out_valid", W'(out_valid), W'(0));
        end else begin
          exp_t e;
          e = sb.pop_front();
          check({e.tag, " data"}, out_data, e.data);
          check("R3 carry", W'(out_carry), W'(e.carry));
          last_data  = e.data;
          last_carry = e.carry;
        end
      end else begin
        check("R10 hold data", out_data, last_data);
        check("R10 hold carry", W'(out_carry), W'(last_carry));
      end
    end
  end

  initial begin
    #(4 * 100000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 out_valid", W'(out_valid), W'(0));
    check("R1 out_data", out_data, W'(0));
    check("R1 out_carry", W'(out_carry), W'(0));
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 out_valid after release", W'(out_valid), W'(0));

    drive(2'b11, 16'h03F0, 6'd7,  "R7 flip 03F0 b7");
    drive(2'b11, 16'h001E, 6'd1,  "R7 flip 001E b1");
    drive(2'b01, 16'h0189, 6'd1,  "R5 set 0189 b1");
    drive(2'b00, 16'h1010, 6'd4,  "R4 test 1010 b4");
    drive(2'b10, 16'h00FF, 6'd0,  "R6 clear 00FF b0");
    idle(2);
    drive(2'b10, 16'hFF00, 6'd3,  "R6 clear already 0");
    drive(2'b01, 16'h8000, 6'd15, "R5 set already 1 top bit");
    drive(2'b11, 16'h0000, 6'd15, "R7 flip top bit");
    drive(2'b11, 16'h0000, 6'd23, "R9 index 23 -> 7");
    drive(2'b10, 16'hFFFF, 6'd63, "R9 index 63 -> 15");
    drive(2'b00, 16'hA5A5, 6'd40, "R9 R4 index 40 -> 8");
    idle(1);
    for (int n = 0; n < 300; n++) begin
      drive(2'($urandom()), W'($urandom()), IW'($urandom()), "R8 random");
      if (($urandom() % 5) == 0) idle(1);
    end
    idle(4);
    checks++;
    if (sb.size() != 0) begin
      fails++;
      $display("FAIL R2 pending results actual=%0d expected=0", sb.size());
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule